// File: doc/BRIEF.md
# Two-Level Variable-Page Address Translator

This block turns 32-bit effective addresses into 32-bit physical addresses for a fetch port and a load/store port. Translations live in a 64-entry fully associative main table that only software fills, through a one-cycle write port. Each entry carries an effective page number, a 3-bit size code, a valid flag, a real page number and two permission flags: execute and write. Entries of different page sizes can sit in the table together. The sizes run from 1KB to 16MB in steps of four.

In front of the main table, each port has a small first-level cache of translations. The fetch side holds 4 entries and the data side holds 8. Hardware alone refills these caches, replacing entries round-robin. A hit in the first-level cache answers one cycle after the request is accepted. A miss searches the main table on the next cycle and answers one cycle after that. Any software write to the main table empties both first-level caches. When translation is disabled, addresses pass through unchanged.

Both ports take requests over valid/ready and return results over valid/ready. A port accepts a request only while it has nothing in flight (`*_req_ready` high). It keeps `*_req_ready` low from acceptance until its response is taken. A response waiting on a low `*_rsp_ready` holds every field steady. Software writes, the translation enable and the result flags are plain signals.

Top module: `xlat_tlb`

## Requirements
- R1: After reset both ports show `*_req_ready`=1 and `*_rsp_valid`=0, and all main-table and first-level entries are invalid.
- R2: A request is taken when valid and ready are both high. Ready then stays low until the response has been taken (valid and ready both high). A response stalled by a low `*_rsp_ready` keeps all fields unchanged.
- R3: If `xlat_en`=0 when a request is accepted, the response comes one cycle later with paddr equal to the request address and hit=0, miss=0, fault=0.
- R4: Size code s (0..7) covers 2^(10+2s) bytes. An entry matches when address bits [31:10+2s] equal the same bits of `wr_epn`<<10. The physical address takes bits [31:10+2s] from `wr_rpn`<<10 and the lower bits from the request address.
- R5: If no valid main entry matches, the response has miss=1, hit=0, fault=0 and paddr=0, two cycles after acceptance.
- R6: A first-level hit responds one cycle after acceptance. A first-level miss with a main hit responds two cycles after acceptance with hit=1 and the translated address.
- R7: A main hit copies the entry into that port's first-level cache at a round-robin slot (4 slots for fetch, 8 for data). Later requests to the same page hit there until the entry is overwritten.
- R8: Every cycle with `wr_en`=1 invalidates all entries of both first-level caches. Later requests must therefore search the main table.
- R9: A data request with `d_req_store`=1 that hits an entry whose write flag is 0, or a fetch that hits an entry whose execute flag is 0, responds with hit=1 and fault=1. Data loads never fault.
- R10: When several valid main entries match, the entry with the lowest index gives the translation.
- R11: When both ports need the main table in the same cycle, the data port is served first and the fetch port one cycle later.
- R12: `wr_en` writes the entry at `wr_idx` with `wr_valid`, and the result is seen by searches from the next cycle on. Writing `wr_valid`=0 removes the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | 1 enables translation, 0 passes addresses through |
| wr_en | input | 1 | Main-table write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_valid | input | 1 | Valid flag written |
| wr_epn | input | 22 | Effective page number (address bits 31:10) |
| wr_rpn | input | 22 | Real page number (address bits 31:10) |
| wr_size | input | 3 | Page size code, 0=1KB .. 7=16MB |
| wr_ex | input | 1 | Execute permission |
| wr_wr | input | 1 | Write permission |
| i_req_valid | input | 1 | Fetch request valid |
| i_req_ready | output | 1 | Fetch port can accept |
| i_req_addr | input | 32 | Fetch effective address |
| i_rsp_valid | output | 1 | Fetch result valid |
| i_rsp_ready | input | 1 | Fetch result taken |
| i_rsp_paddr | output | 32 | Fetch physical address |
| i_rsp_hit | output | 1 | Fetch translation found |
| i_rsp_miss | output | 1 | Fetch has no matching entry |
| i_rsp_fault | output | 1 | Fetch from non-executable page |
| d_req_valid | input | 1 | Data request valid |
| d_req_ready | output | 1 | Data port can accept |
| d_req_addr | input | 32 | Data effective address |
| d_req_store | input | 1 | 1 for a store, 0 for a load |
| d_rsp_valid | output | 1 | Data result valid |
| d_rsp_ready | input | 1 | Data result taken |
| d_rsp_paddr | output | 32 | Data physical address |
| d_rsp_hit | output | 1 | Data translation found |
| d_rsp_miss | output | 1 | Data has no matching entry |
| d_rsp_fault | output | 1 | Store to a non-writable page |

## Verification
A stale first-level entry shows up at the ports right away. The next request to that page answers one cycle early with the old physical address, where the main search should have given the new one two cycles after acceptance. A wrong round-robin pointer or a wrong size mask changes either the response latency or the upper address bits on the very first request that depends on it. The bench therefore predicts ready, valid and every response field in every cycle. A fault in arbitration or in the handshake state shows up as a one-cycle shift in `*_rsp_valid`.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PG_LSB = 10;
  localparam int PN_W   = VA_W - PG_LSB;
  localparam int SZ_W   = 3;

  typedef struct packed {
    logic [PN_W-1:0] epn;
    logic [SZ_W-1:0] sz;
    logic [PN_W-1:0] rpn;
    logic            ex;
    logic            wr;
  } tlb_ent_t;

  typedef struct packed {
    logic [VA_W-1:0] paddr;
    logic            hit;
    logic            miss;
    logic            fault;
  } xl_rsp_t;

  // page-number bits that take part in the compare for a size code
  function automatic logic [PN_W-1:0] pn_mask(input logic [SZ_W-1:0] sz);
    return {PN_W{1'b1}} << (2 * int'(sz));
  endfunction

  function automatic logic pn_match(input logic [PN_W-1:0] pn, input tlb_ent_t e);
    return ((pn ^ e.epn) & pn_mask(e.sz)) == '0;
  endfunction

  function automatic logic [VA_W-1:0] xlate(input logic [VA_W-1:0] va, input tlb_ent_t e);
    logic [PN_W-1:0] m;
    m = pn_mask(e.sz);
    return {(e.rpn & m) | (va[VA_W-1:PG_LSB] & ~m), va[PG_LSB-1:0]};
  endfunction
endpackage

// File: rtl/tlb_main_array.sv
module tlb_main_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic            wr_vld,
  input  tlb_ent_t        wr_ent,
  input  logic [PN_W-1:0] srch_pn,
  output logic            srch_hit,
  output tlb_ent_t        srch_ent
);
  tlb_ent_t           ent_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] hit_v;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_cmp
    assign hit_v[k] = vld_q[k] && pn_match(srch_pn, ent_q[k]);
  end

  // lowest index wins: scan downward so the last assignment is the smallest hit
  always_comb begin
    srch_ent = ent_q[0];
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (hit_v[k]) srch_ent = ent_q[k];
    end
  end
  assign srch_hit = |hit_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= wr_vld;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent_q[wr_idx] <= wr_ent;
  end
endmodule

// File: rtl/tlb_shadow.sv
module tlb_shadow
  import tlb_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PN_W-1:0]  lk_pn,
  output logic             lk_hit,
  output tlb_ent_t         lk_ent,
  input  logic             fill,
  input  tlb_ent_t         fill_ent,
  output logic [DEPTH-1:0] vld_o
);
  tlb_ent_t         ent_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PTR_W-1:0] ptr_q;
  logic [DEPTH-1:0] hit_v;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign hit_v[k] = vld_q[k] && pn_match(lk_pn, ent_q[k]);
  end

  always_comb begin
    lk_ent = ent_q[0];
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (hit_v[k]) lk_ent = ent_q[k];
    end
  end
  assign lk_hit = |hit_v;
  assign vld_o  = vld_q;

  // flush is placed after fill so that it wins in a shared cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      if (fill) begin
        vld_q[ptr_q] <= 1'b1;
        ptr_q        <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
      if (flush) vld_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) ent_q[ptr_q] <= fill_ent;
  end
endmodule

// File: rtl/tlb_side.sv
module tlb_side
  import tlb_pkg::*;
#(
  parameter int SH_DEPTH = 4,
  parameter bit IS_DATA  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xlat_en,
  input  logic                flush,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_addr,
  input  logic                req_store,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output xl_rsp_t             rsp,
  output logic                main_req,
  output logic [PN_W-1:0]     main_pn,
  input  logic                main_gnt,
  input  logic                main_hit,
  input  tlb_ent_t            main_ent,
  output logic [SH_DEPTH-1:0] sh_vld
);
  typedef enum logic [1:0] {S_IDLE, S_MAIN, S_RSP} st_t;

  st_t             st_q;
  logic [VA_W-1:0] va_q;
  logic            store_q;
  xl_rsp_t         rsp_q;
  logic            sh_hit;
  tlb_ent_t        sh_ent;
  logic            fill;

  function automatic xl_rsp_t hit_rsp(input logic [VA_W-1:0] va, input logic st,
                                      input tlb_ent_t e);
    xl_rsp_t r;
    r.paddr = xlate(va, e);
    r.hit   = 1'b1;
    r.miss  = 1'b0;
    r.fault = IS_DATA ? (st && !e.wr) : !e.ex;
    return r;
  endfunction

  assign fill = (st_q == S_MAIN) && main_gnt && main_hit;

  tlb_shadow #(.DEPTH(SH_DEPTH)) u_sh (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_pn    (req_addr[VA_W-1:PG_LSB]),
    .lk_hit   (sh_hit),
    .lk_ent   (sh_ent),
    .fill     (fill),
    .fill_ent (main_ent),
    .vld_o    (sh_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      va_q    <= '0;
      store_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          va_q    <= req_addr;
          store_q <= req_store;
          if (!xlat_en) begin
            rsp_q <= '{paddr: req_addr, hit: 1'b0, miss: 1'b0, fault: 1'b0};
            st_q  <= S_RSP;
          end else if (sh_hit) begin
            rsp_q <= hit_rsp(req_addr, req_store, sh_ent);
            st_q  <= S_RSP;
          end else begin
            st_q  <= S_MAIN;
          end
        end
        S_MAIN: if (main_gnt) begin
          rsp_q <= main_hit ? hit_rsp(va_q, store_q, main_ent)
                            : '{paddr: '0, hit: 1'b0, miss: 1'b1, fault: 1'b0};
          st_q  <= S_RSP;
        end
        S_RSP: if (rsp_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign rsp_valid = (st_q == S_RSP);
  assign rsp       = rsp_q;
  assign main_req  = (st_q == S_MAIN);
  assign main_pn   = va_q[VA_W-1:PG_LSB];
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int MAIN_ENTRIES = 64,
  parameter int I_SH_DEPTH   = 4,
  parameter int D_SH_DEPTH   = 8,
  localparam int MIDX_W      = $clog2(MAIN_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlat_en,
  input  logic              wr_en,
  input  logic [MIDX_W-1:0] wr_idx,
  input  logic              wr_valid,
  input  logic [21:0]       wr_epn,
  input  logic [21:0]       wr_rpn,
  input  logic [2:0]        wr_size,
  input  logic              wr_ex,
  input  logic              wr_wr,
  input  logic              i_req_valid,
  output logic              i_req_ready,
  input  logic [31:0]       i_req_addr,
  output logic              i_rsp_valid,
  input  logic              i_rsp_ready,
  output logic [31:0]       i_rsp_paddr,
  output logic              i_rsp_hit,
  output logic              i_rsp_miss,
  output logic              i_rsp_fault,
  input  logic              d_req_valid,
  output logic              d_req_ready,
  input  logic [31:0]       d_req_addr,
  input  logic              d_req_store,
  output logic              d_rsp_valid,
  input  logic              d_rsp_ready,
  output logic [31:0]       d_rsp_paddr,
  output logic              d_rsp_hit,
  output logic              d_rsp_miss,
  output logic              d_rsp_fault
);
  tlb_ent_t          wr_ent;
  logic              i_main_req, d_main_req, i_gnt, d_gnt;
  logic [PN_W-1:0]   i_main_pn, d_main_pn, srch_pn;
  logic              srch_hit;
  tlb_ent_t          srch_ent;
  xl_rsp_t           i_rsp, d_rsp;
  logic [I_SH_DEPTH-1:0] i_sh_vld;
  logic [D_SH_DEPTH-1:0] d_sh_vld;

  assign wr_ent = '{epn: wr_epn, sz: wr_size, rpn: wr_rpn, ex: wr_ex, wr: wr_wr};

  // fixed priority: the data side owns the main search when both wait
  assign d_gnt   = d_main_req;
  assign i_gnt   = i_main_req && !d_main_req;
  assign srch_pn = d_main_req ? d_main_pn : i_main_pn;

  tlb_main_array #(.ENTRIES(MAIN_ENTRIES)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_vld   (wr_valid),
    .wr_ent   (wr_ent),
    .srch_pn  (srch_pn),
    .srch_hit (srch_hit),
    .srch_ent (srch_ent)
  );

  tlb_side #(.SH_DEPTH(I_SH_DEPTH), .IS_DATA(1'b0)) u_side_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .xlat_en   (xlat_en),
    .flush     (wr_en),
    .req_valid (i_req_valid),
    .req_ready (i_req_ready),
    .req_addr  (i_req_addr),
    .req_store (1'b0),
    .rsp_valid (i_rsp_valid),
    .rsp_ready (i_rsp_ready),
    .rsp       (i_rsp),
    .main_req  (i_main_req),
    .main_pn   (i_main_pn),
    .main_gnt  (i_gnt),
    .main_hit  (srch_hit),
    .main_ent  (srch_ent),
    .sh_vld    (i_sh_vld)
  );

  tlb_side #(.SH_DEPTH(D_SH_DEPTH), .IS_DATA(1'b1)) u_side_d (
    .clk       (clk),
    .rst_n     (rst_n),
    .xlat_en   (xlat_en),
    .flush     (wr_en),
    .req_valid (d_req_valid),
    .req_ready (d_req_ready),
    .req_addr  (d_req_addr),
    .req_store (d_req_store),
    .rsp_valid (d_rsp_valid),
    .rsp_ready (d_rsp_ready),
    .rsp       (d_rsp),
    .main_req  (d_main_req),
    .main_pn   (d_main_pn),
    .main_gnt  (d_gnt),
    .main_hit  (srch_hit),
    .main_ent  (srch_ent),
    .sh_vld    (d_sh_vld)
  );

  assign i_rsp_paddr = i_rsp.paddr;
  assign i_rsp_hit   = i_rsp.hit;
  assign i_rsp_miss  = i_rsp.miss;
  assign i_rsp_fault = i_rsp.fault;
  assign d_rsp_paddr = d_rsp.paddr;
  assign d_rsp_hit   = d_rsp.hit;
  assign d_rsp_miss  = d_rsp.miss;
  assign d_rsp_fault = d_rsp.fault;
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int I_SH = 4,
  parameter int D_SH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            i_req_valid,
  input logic            i_req_ready,
  input logic            i_rsp_valid,
  input logic            i_rsp_ready,
  input logic [31:0]     i_rsp_paddr,
  input logic            i_rsp_hit,
  input logic            i_rsp_miss,
  input logic            i_rsp_fault,
  input logic            d_req_valid,
  input logic            d_req_ready,
  input logic            d_rsp_valid,
  input logic            d_rsp_ready,
  input logic [31:0]     d_rsp_paddr,
  input logic            d_rsp_hit,
  input logic            d_rsp_miss,
  input logic            d_rsp_fault,
  input logic [I_SH-1:0] i_sh_vld,
  input logic [D_SH-1:0] d_sh_vld
);
  AST_I_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    i_rsp_valid && !i_rsp_ready |=> i_rsp_valid && $stable(i_rsp_paddr)
      && $stable({i_rsp_hit, i_rsp_miss, i_rsp_fault})); // R2
  AST_D_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    d_rsp_valid && !d_rsp_ready |=> d_rsp_valid && $stable(d_rsp_paddr)
      && $stable({d_rsp_hit, d_rsp_miss, d_rsp_fault})); // R2
  AST_I_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    i_req_valid && i_req_ready |=> !i_req_ready); // R2
  AST_D_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    d_req_valid && d_req_ready |=> !d_req_ready); // R2
  AST_I_OUTCOME_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    i_rsp_valid |-> !(i_rsp_hit && i_rsp_miss) && (!i_rsp_fault || i_rsp_hit)); // R9
  AST_D_OUTCOME_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    d_rsp_valid |-> !(d_rsp_hit && d_rsp_miss) && (!d_rsp_fault || d_rsp_hit)); // R9
  AST_D_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    d_rsp_valid && d_rsp_miss |-> !d_rsp_fault && d_rsp_paddr == 32'h0); // R5
  AST_I_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    i_rsp_valid && i_rsp_miss |-> !i_rsp_fault && i_rsp_paddr == 32'h0); // R5
  AST_WRITE_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> i_sh_vld == '0 && d_sh_vld == '0); // R8
endmodule

bind xlat_tlb xlat_tlb_chk #(.I_SH(I_SH_DEPTH), .D_SH(D_SH_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .i_req_valid (i_req_valid),
  .i_req_ready (i_req_ready),
  .i_rsp_valid (i_rsp_valid),
  .i_rsp_ready (i_rsp_ready),
  .i_rsp_paddr (i_rsp_paddr),
  .i_rsp_hit   (i_rsp_hit),
  .i_rsp_miss  (i_rsp_miss),
  .i_rsp_fault (i_rsp_fault),
  .d_req_valid (d_req_valid),
  .d_req_ready (d_req_ready),
  .d_rsp_valid (d_rsp_valid),
  .d_rsp_ready (d_rsp_ready),
  .d_rsp_paddr (d_rsp_paddr),
  .d_rsp_hit   (d_rsp_hit),
  .d_rsp_miss  (d_rsp_miss),
  .d_rsp_fault (d_rsp_fault),
  .i_sh_vld    (i_sh_vld),
  .d_sh_vld    (d_sh_vld)
);

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        xlat_en = 1'b0;
  logic        wr_en = 1'b0, wr_valid = 1'b0, wr_ex = 1'b0, wr_wr = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [21:0] wr_epn = '0, wr_rpn = '0;
  logic [2:0]  wr_size = '0;
  logic        i_req_valid = 1'b0, i_rsp_ready = 1'b1;
  logic [31:0] i_req_addr = '0;
  logic        d_req_valid = 1'b0, d_req_store = 1'b0, d_rsp_ready = 1'b1;
  logic [31:0] d_req_addr = '0;
  logic        i_req_ready, i_rsp_valid, i_rsp_hit, i_rsp_miss, i_rsp_fault;
  logic        d_req_ready, d_rsp_valid, d_rsp_hit, d_rsp_miss, d_rsp_fault;
  logic [31:0] i_rsp_paddr, d_rsp_paddr;

  xlat_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_epn(wr_epn),
    .wr_rpn(wr_rpn), .wr_size(wr_size), .wr_ex(wr_ex), .wr_wr(wr_wr),
    .i_req_valid(i_req_valid), .i_req_ready(i_req_ready), .i_req_addr(i_req_addr),
    .i_rsp_valid(i_rsp_valid), .i_rsp_ready(i_rsp_ready), .i_rsp_paddr(i_rsp_paddr),
    .i_rsp_hit(i_rsp_hit), .i_rsp_miss(i_rsp_miss), .i_rsp_fault(i_rsp_fault),
    .d_req_valid(d_req_valid), .d_req_ready(d_req_ready), .d_req_addr(d_req_addr),
    .d_req_store(d_req_store), .d_rsp_valid(d_rsp_valid), .d_rsp_ready(d_rsp_ready),
    .d_rsp_paddr(d_rsp_paddr), .d_rsp_hit(d_rsp_hit), .d_rsp_miss(d_rsp_miss),
    .d_rsp_fault(d_rsp_fault)
  );

  int    checks = 0, failures = 0, cyc = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference ----------------
  bit          mv[64];
  int unsigned mepn[64], msz[64], mrpn[64];
  bit          mex[64], mwr[64];
  bit          sv[2][8];
  int unsigned sepn[2][8], ssz[2][8], srpn[2][8];
  bit          sex[2][8], swr[2][8];
  int          rrp[2];
  int          dep[2] = '{4, 8};
  int          ms[2];           // 0 idle, 1 waiting for main table, 2 answer held
  logic [31:0] ma[2], ep[2];
  bit          mst[2], eh[2], em[2], ef[2];

  function automatic bit covers(int unsigned epn, int unsigned sz, logic [31:0] a);
    longint unsigned ob = 10 + 2 * sz;
    return ((longint'(a) >> ob) == ((longint'(epn) << 10) >> ob));
  endfunction

  function automatic logic [31:0] mapped(int unsigned rpn, int unsigned sz, logic [31:0] a);
    longint unsigned ob = 10 + 2 * sz;
    longint unsigned base = ((longint'(rpn) << 10) >> ob) << ob;
    longint unsigned off = longint'(a) & ((64'd1 << ob) - 1);
    return 32'(base | off);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mv[k]) mv[k] = 1'b0;
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 8; k++) sv[s][k] = 1'b0;
        rrp[s] = 0; ms[s] = 0;
      end
    end else begin
      bit dwait;
      dwait = (ms[1] == 1);
      for (int s = 1; s >= 0; s--) begin
        bit rv, rs, rdy; logic [31:0] ra; int f;
        rv  = s ? d_req_valid : i_req_valid;
        ra  = s ? d_req_addr : i_req_addr;
        rs  = s ? d_req_store : 1'b0;
        rdy = s ? d_rsp_ready : i_rsp_ready;
        if (ms[s] == 0) begin
          if (rv) begin
            ma[s] = ra; mst[s] = rs;
            if (!xlat_en) begin
              ep[s] = ra; eh[s] = 0; em[s] = 0; ef[s] = 0; ms[s] = 2;
            end else begin
              f = -1;
              for (int k = 0; k < dep[s]; k++)
                if (f < 0 && sv[s][k] && covers(sepn[s][k], ssz[s][k], ra)) f = k;
              if (f >= 0) begin
                ep[s] = mapped(srpn[s][f], ssz[s][f], ra); eh[s] = 1; em[s] = 0;
                ef[s] = s ? (rs && !swr[s][f]) : !sex[s][f];
                ms[s] = 2;
              end else ms[s] = 1;
            end
          end
        end else if (ms[s] == 1) begin
          if (s == 1 || !dwait) begin
            f = -1;
            for (int k = 0; k < 64; k++)
              if (f < 0 && mv[k] && covers(mepn[k], msz[k], ma[s])) f = k;
            if (f >= 0) begin
              ep[s] = mapped(mrpn[f], msz[f], ma[s]); eh[s] = 1; em[s] = 0;
              ef[s] = s ? (mst[s] && !mwr[f]) : !mex[f];
              sv[s][rrp[s]] = 1; sepn[s][rrp[s]] = mepn[f]; ssz[s][rrp[s]] = msz[f];
              srpn[s][rrp[s]] = mrpn[f]; sex[s][rrp[s]] = mex[f]; swr[s][rrp[s]] = mwr[f];
              rrp[s] = (rrp[s] + 1) % dep[s];
            end else begin
              ep[s] = 32'h0; eh[s] = 0; em[s] = 1; ef[s] = 0;
            end
            ms[s] = 2;
          end
        end else if (rdy) ms[s] = 0;
      end
      if (wr_en) begin
        mv[wr_idx] = wr_valid; mepn[wr_idx] = wr_epn; msz[wr_idx] = wr_size;
        mrpn[wr_idx] = wr_rpn; mex[wr_idx] = wr_ex; mwr[wr_idx] = wr_wr;
        for (int s = 0; s < 2; s++) for (int k = 0; k < 8; k++) sv[s][k] = 0;
      end
    end
  end

  // ---------------- comparison every clock ----------------
  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h at cycle %0d", cur_req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("i_req_ready", 32'(i_req_ready), 32'(ms[0] == 0));
      chk("i_rsp_valid", 32'(i_rsp_valid), 32'(ms[0] == 2));
      chk("d_req_ready", 32'(d_req_ready), 32'(ms[1] == 0));
      chk("d_rsp_valid", 32'(d_rsp_valid), 32'(ms[1] == 2));
      if (ms[0] == 2) begin
        chk("i_paddr", i_rsp_paddr, ep[0]);
        chk("i_flags", {29'd0, i_rsp_hit, i_rsp_miss, i_rsp_fault}, {29'd0, eh[0], em[0], ef[0]});
      end
      if (ms[1] == 2) begin
        chk("d_paddr", d_rsp_paddr, ep[1]);
        chk("d_flags", {29'd0, d_rsp_hit, d_rsp_miss, d_rsp_fault}, {29'd0, eh[1], em[1], ef[1]});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int idx, input bit v, input logic [31:0] ea, input logic [31:0] pa,
                    input int sz, input bit ex, input bit w);
    @(negedge clk);
    wr_en = 1; wr_idx = 6'(idx); wr_valid = v; wr_epn = ea[31:10]; wr_rpn = pa[31:10];
    wr_size = 3'(sz); wr_ex = ex; wr_wr = w;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic acc(input int s, input logic [31:0] a, input bit st);
    @(negedge clk);
    while (!(s ? d_req_ready : i_req_ready)) @(negedge clk);
    if (s) begin d_req_valid = 1; d_req_addr = a; d_req_store = st; end
    else begin i_req_valid = 1; i_req_addr = a; end
    @(negedge clk);
    if (s) d_req_valid = 0; else i_req_valid = 0;
    while (!(s ? d_rsp_valid : i_rsp_valid)) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);          // R1: reset state compared on these cycles

    cur_req = "R3";                      // pass-through when disabled
    acc(0, 32'h1234_5678, 0);
    acc(1, 32'hDEAD_BEEF, 1);

    cur_req = "R12";                     // load entries of mixed sizes
    wr(0,  1, 32'h1000_0000, 32'h8000_0000, 0, 1, 1);
    wr(1,  1, 32'h2000_0000, 32'h4100_0000, 7, 0, 1);
    wr(2,  1, 32'h3001_0000, 32'h5002_0000, 3, 1, 0);
    wr(3,  1, 32'h2040_0000, 32'h7000_0000, 2, 1, 1);
    wr(6,  1, 32'h6000_1000, 32'h1111_1000, 1, 1, 1);
    wr(9,  1, 32'h6000_0000, 32'h2220_0000, 5, 1, 1);
    wr(10, 1, 32'h4004_0000, 32'h900C_0000, 4, 1, 1);
    wr(11, 1, 32'h0C00_0000, 32'h0340_0000, 6, 1, 1);
    wr(63, 1, 32'h7000_0000, 32'h0A00_0000, 5, 1, 1);
    xlat_en = 1;

    cur_req = "R5";
    acc(1, 32'h0000_0400, 0);
    acc(0, 32'hF000_0000, 0);

    cur_req = "R6";                      // main then first-level hit
    acc(1, 32'h1000_0123, 0);
    acc(1, 32'h1000_03FC, 0);

    cur_req = "R4";                      // every size in use
    acc(1, 32'h20AB_CDEF, 0);
    acc(1, 32'h3001_FFFF, 0);
    acc(1, 32'h4007_1234, 0);
    acc(1, 32'h0FFF_FFF0, 0);
    acc(1, 32'h700F_0001, 0);

    cur_req = "R9";                      // permissions
    acc(1, 32'h3001_2345, 1);
    acc(1, 32'h3001_2345, 0);
    acc(0, 32'h2000_0010, 0);
    acc(0, 32'h3001_1000, 0);
    acc(1, 32'h1000_0010, 1);

    cur_req = "R10";                     // overlap: lower index wins
    acc(1, 32'h6000_1234, 0);
    acc(1, 32'h6000_2234, 0);
    acc(1, 32'h2040_0100, 0);

    cur_req = "R8";                      // write empties first-level caches
    wr(0, 1, 32'h1000_0000, 32'h8800_0000, 0, 1, 1);
    acc(1, 32'h1000_0123, 0);
    acc(1, 32'h1000_0124, 0);

    cur_req = "R7";                      // five pages through 4 fetch slots and 8 data slots
    wr(5, 0, 32'h0, 32'h0, 0, 0, 0);
    acc(0, 32'h1000_0000, 0);
    acc(0, 32'h3001_0000, 0);
    acc(0, 32'h6000_1000, 0);
    acc(0, 32'h6000_2000, 0);
    acc(0, 32'h7000_0000, 0);
    acc(0, 32'h1000_0004, 0);
    acc(1, 32'h1000_0000, 0);
    acc(1, 32'h3001_0000, 0);
    acc(1, 32'h6000_1000, 0);
    acc(1, 32'h6000_2000, 0);
    acc(1, 32'h7000_0000, 0);
    acc(1, 32'h1000_0004, 0);

    cur_req = "R11";                     // both ports miss together
    wr(4, 0, 32'h0, 32'h0, 0, 0, 0);
    fork
      acc(0, 32'h4004_0010, 0);
      acc(1, 32'h700A_0000, 1);
    join

    cur_req = "R2";                      // held response under back-pressure
    d_rsp_ready = 0;
    acc(1, 32'h6000_1555, 0);
    repeat (4) @(negedge clk);
    d_rsp_ready = 1;
    i_rsp_ready = 0;
    acc(0, 32'h0000_0000, 0);
    repeat (3) @(negedge clk);
    i_rsp_ready = 1;

    cur_req = "R12";                     // removal of a translation
    wr(63, 0, 32'h7000_0000, 32'h0A00_0000, 5, 1, 1);
    acc(1, 32'h7000_0000, 0);

    cur_req = "R3";                      // disable again after loading
    xlat_en = 0;
    acc(0, 32'h1000_0123, 0);
    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule